// File: doc/BRIEF.md
# Five-Stage Pipeline Control Staging

This block produces and carries the control signals of a five-stage in-order pipeline. An opcode, two register-number fields and a bubble request arrive in the decode stage. The decoder turns the opcode into three groups of control signals:

- an execute group,
- a memory group,
- a writeback group.

The groups move forward through the decode/execute, execute/memory and memory/writeback registers. Each group leaves the pipeline in the stage that uses it. The destination register number is chosen in execute and then travels with the writeback controls.

The block also holds the register file that decode reads. Writeback writes it from the memory/writeback stage. A read of the register being written in the same cycle returns the value being written, so a producer three instructions ahead is seen by decode without a stall.

The fetch stage is not part of this block, because it has no optional controls. Datapath arithmetic, forwarding and hazard policy are also outside it. When hazard logic wants a no-op in a slot, it asserts the bubble input.

Top module: `pipe_ctl`

## Requirements
- R1: Opcode 6'b000000 (register-register) gives execute controls dest-from-d=1, alu_op=2'b10, alu_src=0; memory controls branch=0, read=0, write=0; writeback controls reg_write=1, mem_to_reg=0.
- R2: Opcode 6'b100011 (load) gives dest-from-d=0, alu_op=2'b00, alu_src=1; branch=0, read=1, write=0; reg_write=1, mem_to_reg=1.
- R3: Opcode 6'b101011 (store) gives dest-from-d=0, alu_op=2'b00, alu_src=1; branch=0, read=0, write=1; reg_write=0, mem_to_reg=0. A slot never has the memory read and the memory write both set.
- R4: Opcode 6'b000100 (branch-if-equal) gives dest-from-d=0, alu_op=2'b01, alu_src=0; branch=1, read=0, write=0; reg_write=0, mem_to_reg=0.
- R5: Every other opcode decodes to all-zero controls (a no-op).
- R6: The controls of an instruction presented in decode appear on the execute ports after 1 rising edge, on the memory ports after 2 rising edges, and on the writeback ports after 3 rising edges.
- R7: `ex_dest` equals the d field when dest-from-d is 1 and the t field otherwise. That value appears on `wb_dest` two edges later.
- R8: While `id_bubble` is 1, the slot being loaded gets reg_write, memory read, memory write and branch forced to 0. Its alu_op, alu_src, dest-from-d and mem_to_reg are kept as decoded.
- R9: A synchronous reset clears every pipeline control field to the no-op state and every register of the register file to 0.
- R10: On a rising edge with `wb_reg_write`=1, the register numbered `wb_dest` takes `wb_data`. In the same cycle, a read of that register returns `wb_data`.
- R11: The two read ports are independent. A port whose address differs from the one being written returns the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| id_opcode | input | 6 | Opcode of the instruction in decode |
| id_fld_t | input | 5 | t register field in decode |
| id_fld_d | input | 5 | d register field in decode |
| id_bubble | input | 1 | Turns the slot being loaded into a no-op |
| id_src_a | input | 5 | Register file read address, port A |
| id_src_b | input | 5 | Register file read address, port B |
| id_val_a | output | 32 | Read data, port A |
| id_val_b | output | 32 | Read data, port B |
| ex_dest_sel | output | 1 | Execute: take destination from the d field |
| ex_alu_op | output | 2 | Execute: ALU operation class |
| ex_alu_src | output | 1 | Execute: second ALU operand is the immediate |
| ex_dest | output | 5 | Execute: selected destination register |
| mem_branch | output | 1 | Memory: branch |
| mem_read | output | 1 | Memory: data read |
| mem_write | output | 1 | Memory: data write |
| wb_reg_write | output | 1 | Writeback: register write enable |
| wb_mem_to_reg | output | 1 | Writeback: result comes from memory |
| wb_dest | output | 5 | Writeback: destination register |
| wb_data | input | 32 | Writeback data written to the register file |

## Verification
Two things can happen in one cycle: the writeback stage writing a register, and decode reading that same register. The bench sends a register-register instruction down the pipeline. When its writeback controls reach the outputs, it points read port A at the destination and read port B at another register, then drives `wb_data` before the edge. Port A must return the new value at once and keep it after the edge, while port B keeps its stored value.

// File: rtl/pipe_ctl.sv
module pipe_ctl #(
  parameter int DW   = 32,
  parameter int AW   = 5,
  parameter int OPW  = 6,
  parameter int NREG = 1 << AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [OPW-1:0] id_opcode,
  input  logic [AW-1:0] id_fld_t,
  input  logic [AW-1:0] id_fld_d,
  input  logic          id_bubble,
  input  logic [AW-1:0] id_src_a,
  input  logic [AW-1:0] id_src_b,
  output logic [DW-1:0] id_val_a,
  output logic [DW-1:0] id_val_b,
  output logic          ex_dest_sel,
  output logic [1:0]    ex_alu_op,
  output logic          ex_alu_src,
  output logic [AW-1:0] ex_dest,
  output logic          mem_branch,
  output logic          mem_read,
  output logic          mem_write,
  output logic          wb_reg_write,
  output logic          wb_mem_to_reg,
  output logic [AW-1:0] wb_dest,
  input  logic [DW-1:0] wb_data
);
  localparam logic [OPW-1:0] OP_RR  = OPW'(6'b000000);
  localparam logic [OPW-1:0] OP_LD  = OPW'(6'b100011);
  localparam logic [OPW-1:0] OP_ST  = OPW'(6'b101011);
  localparam logic [OPW-1:0] OP_BEQ = OPW'(6'b000100);

  logic       d_sel, d_asrc, d_br, d_rd, d_wr, d_rw, d_m2r;
  logic [1:0] d_aop;

  always_comb begin
    {d_sel, d_aop, d_asrc, d_br, d_rd, d_wr, d_rw, d_m2r} = '0;
    case (id_opcode)
      OP_RR:  begin d_sel = 1'b1; d_aop = 2'b10; d_rw = 1'b1; end
      OP_LD:  begin d_asrc = 1'b1; d_rd = 1'b1; d_rw = 1'b1; d_m2r = 1'b1; end
      OP_ST:  begin d_asrc = 1'b1; d_wr = 1'b1; end
      OP_BEQ: begin d_aop = 2'b01; d_br = 1'b1; end
      default: ;
    endcase
  end

  logic          ie_br, ie_rd, ie_wr, ie_rw, ie_m2r;
  logic [AW-1:0] ie_t, ie_d;
  logic          em_rw, em_m2r;
  logic [AW-1:0] em_dest;
  logic          mw_rw, mw_m2r;
  logic [AW-1:0] mw_dest;

  always_ff @(posedge clk) begin
    if (rst) begin
      ex_dest_sel <= 1'b0; ex_alu_op <= 2'b00; ex_alu_src <= 1'b0;
      ie_br <= 1'b0; ie_rd <= 1'b0; ie_wr <= 1'b0; ie_rw <= 1'b0; ie_m2r <= 1'b0;
      ie_t <= '0; ie_d <= '0;
    end else begin
      ex_dest_sel <= d_sel;
      ex_alu_op   <= d_aop;
      ex_alu_src  <= d_asrc;
      ie_br  <= d_br & ~id_bubble;
      ie_rd  <= d_rd & ~id_bubble;
      ie_wr  <= d_wr & ~id_bubble;
      ie_rw  <= d_rw & ~id_bubble;
      ie_m2r <= d_m2r;
      ie_t   <= id_fld_t;
      ie_d   <= id_fld_d;
    end
  end

  assign ex_dest = ex_dest_sel ? ie_d : ie_t;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_branch <= 1'b0; mem_read <= 1'b0; mem_write <= 1'b0;
      em_rw <= 1'b0; em_m2r <= 1'b0; em_dest <= '0;
      mw_rw <= 1'b0; mw_m2r <= 1'b0; mw_dest <= '0;
    end else begin
      mem_branch <= ie_br;
      mem_read   <= ie_rd;
      mem_write  <= ie_wr;
      em_rw      <= ie_rw;
      em_m2r     <= ie_m2r;
      em_dest    <= ex_dest;
      mw_rw      <= em_rw;
      mw_m2r     <= em_m2r;
      mw_dest    <= em_dest;
    end
  end

  assign wb_reg_write  = mw_rw;
  assign wb_mem_to_reg = mw_m2r;
  assign wb_dest       = mw_dest;

  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (mw_rw) begin
      regs[mw_dest] <= wb_data;
    end
  end

  assign id_val_a = (mw_rw && mw_dest == id_src_a) ? wb_data : regs[id_src_a];
  assign id_val_b = (mw_rw && mw_dest == id_src_b) ? wb_data : regs[id_src_b];

  AST_BUBBLE_NOOP: assert property (@(posedge clk) disable iff (rst)
    $past(id_bubble) |-> !(ie_rw || ie_rd || ie_wr || ie_br)); // R8
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !(mem_read || mem_write || mem_branch || wb_reg_write)); // R9
  AST_MEM_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(mem_read && mem_write)); // R3
  AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (rst)
    mem_write |-> !em_rw); // R3
  AST_BRANCH_QUIET: assert property (@(posedge clk) disable iff (rst)
    mem_branch |-> !(mem_read || em_rw)); // R4
  AST_WRITE_HELD: assert property (@(posedge clk) disable iff (rst)
    ($past(wb_reg_write) && $past(wb_dest) == id_src_a && !(wb_reg_write && wb_dest == id_src_a))
    |-> id_val_a == $past(wb_data)); // R10
endmodule

// File: tb/pipe_ctl_bench.sv
`timescale 1ns/1ps
module pipe_ctl_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst;
  logic [5:0]  id_opcode;
  logic [4:0]  id_fld_t, id_fld_d, id_src_a, id_src_b;
  logic        id_bubble;
  logic [31:0] id_val_a, id_val_b, wb_data;
  logic        ex_dest_sel, ex_alu_src, mem_branch, mem_read, mem_write, wb_reg_write, wb_mem_to_reg;
  logic [1:0]  ex_alu_op;
  logic [4:0]  ex_dest, wb_dest;

  pipe_ctl u_pipe_ctl (
    .clk(clk), .rst(rst), .id_opcode(id_opcode), .id_fld_t(id_fld_t), .id_fld_d(id_fld_d),
    .id_bubble(id_bubble), .id_src_a(id_src_a), .id_src_b(id_src_b),
    .id_val_a(id_val_a), .id_val_b(id_val_b), .ex_dest_sel(ex_dest_sel), .ex_alu_op(ex_alu_op),
    .ex_alu_src(ex_alu_src), .ex_dest(ex_dest), .mem_branch(mem_branch), .mem_read(mem_read),
    .mem_write(mem_write), .wb_reg_write(wb_reg_write), .wb_mem_to_reg(wb_mem_to_reg),
    .wb_dest(wb_dest), .wb_data(wb_data));

  int errors = 0, checks = 0;
  bit done = 0;

  // op t d bub | sel aop asrc | br rd wr | rw m2r | dest
  localparam int NV = 9;
  localparam logic [30:0] VEC [NV] = '{
    {6'h00, 5'd2,  5'd3,  1'b0, 1'b1, 2'b10, 1'b0, 3'b000, 2'b10, 5'd3},
    {6'h23, 5'd4,  5'd9,  1'b0, 1'b0, 2'b00, 1'b1, 3'b010, 2'b11, 5'd4},
    {6'h2B, 5'd7,  5'd8,  1'b0, 1'b0, 2'b00, 1'b1, 3'b001, 2'b00, 5'd7},
    {6'h04, 5'd10, 5'd11, 1'b0, 1'b0, 2'b01, 1'b0, 3'b100, 2'b00, 5'd10},
    {6'h3F, 5'd12, 5'd13, 1'b0, 1'b0, 2'b00, 1'b0, 3'b000, 2'b00, 5'd12},
    {6'h23, 5'd14, 5'd15, 1'b1, 1'b0, 2'b00, 1'b1, 3'b000, 2'b01, 5'd14},
    {6'h00, 5'd16, 5'd17, 1'b1, 1'b1, 2'b10, 1'b0, 3'b000, 2'b00, 5'd17},
    {6'h00, 5'd31, 5'd30, 1'b0, 1'b1, 2'b10, 1'b0, 3'b000, 2'b10, 5'd30},
    {6'h2B, 5'd1,  5'd2,  1'b1, 1'b0, 2'b00, 1'b1, 3'b000, 2'b00, 5'd1}
  };

  function automatic string tag_of(logic [30:0] v);
    if (v[14]) return "R8";
    case (v[30:25])
      6'h00: return "R1";
      6'h23: return "R2";
      6'h2B: return "R3";
      6'h04: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(logic [5:0] op, logic [4:0] t, logic [4:0] d, logic b);
    id_opcode = op; id_fld_t = t; id_fld_d = d; id_bubble = b;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    drive(6'h3F, 5'd0, 5'd0, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic chk_idle(string req);
    chk(req, "exec ctl", {ex_dest_sel, ex_alu_op, ex_alu_src}, 0);
    chk(req, "mem ctl", {mem_branch, mem_read, mem_write}, 0);
    chk(req, "wb ctl", {wb_reg_write, wb_mem_to_reg, wb_dest}, 0);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    id_src_a = 5'd5; id_src_b = 5'd6; wb_data = '0;
    do_reset();
    chk_idle("R9");
    chk("R9", "reg5 after reset", id_val_a, 0);

    // Table walk: in step i, exec holds vector i, mem holds i-1, wb holds i-2 (R6)
    for (int i = 0; i < NV + 2; i++) begin
      if (i < NV) drive(VEC[i][30:25], VEC[i][24:20], VEC[i][19:15], VEC[i][14]);
      else drive(6'h3F, 5'd0, 5'd0, 1'b0);
      @(posedge clk);
      @(negedge clk);
      if (i < NV) begin
        chk(tag_of(VEC[i]), "exec ctl", {ex_dest_sel, ex_alu_op, ex_alu_src}, VEC[i][13:10]);
        chk("R7", "ex_dest", ex_dest, VEC[i][4:0]);
      end
      if (i >= 1 && i - 1 < NV)
        chk(tag_of(VEC[i-1]), "R6 mem ctl", {mem_branch, mem_read, mem_write}, VEC[i-1][9:7]);
      if (i >= 2) begin
        chk(tag_of(VEC[i-2]), "R6 wb ctl", {wb_reg_write, wb_mem_to_reg}, VEC[i-2][6:5]);
        chk("R7", "wb_dest", wb_dest, VEC[i-2][4:0]);
      end
    end

    // Same-cycle write and read through the register file
    drive(6'h00, 5'd1, 5'd5, 1'b0);
    @(posedge clk); @(negedge clk);
    drive(6'h3F, 5'd0, 5'd0, 1'b0);
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R6", "wb write en", wb_reg_write, 1);
    chk("R7", "wb_dest", wb_dest, 5);
    id_src_a = 5'd5; id_src_b = 5'd6; wb_data = 32'hCAFE0005;
    #1;
    chk("R10", "same-cycle read", id_val_a, 32'hCAFE0005);
    chk("R11", "other port", id_val_b, 0);
    @(posedge clk); @(negedge clk);
    wb_data = 32'h0;
    #1;
    chk("R10", "stored value", id_val_a, 32'hCAFE0005);
    chk("R11", "other port after", id_val_b, 0);

    do_reset();
    chk_idle("R9");
    chk("R9", "reg5 cleared", id_val_a, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule